// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Serial Key Codes

This block watches a key matrix of four columns and eight rows. A 5-bit scan index walks through all 32 crossings, one per clock. The upper two bits pick the single column that is driven and the lower three bits pick the row that is sampled. When the sampled row reads high, the index stops and becomes the identity of the pressed key. The block then reports that key on one serial line. The line is active low, sends the least significant bit first at one bit per clock, and its idle (high) level means logic 0.

Command keys send a 7-bit code built from the key position. Digit keys take part in a two-step exchange. First they send a generic "digit pressed" code, and which of the two codes is used depends on whether the decimal point has been entered. The block then stays frozen until the downstream logic pulls the active-low figure strobe low. While the strobe is low, the block shifts out the 4-bit BCD value of the digit. A busy input holds off new reports. A clear input aborts any exchange and restarts the scan.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While `rst` is high, `kd_n` is high and `col_drive` is 4'b0001 on the following clock.
- R2: Exactly one bit of `col_drive` is high. With no key pressed, the scan index advances by one per clock from 0 and wraps after 31. The driven column is bits 4:3 of the index, so after k clocks from reset release the active column is (k mod 32) / 8.
- R3: A key at column c, row r with index 8c+r from 11 to 31 is a command. It sends the 7-bit code with bit 0 = 1, bits 3:1 = r, bits 5:4 = c and bit 6 = 0. The code goes out least significant bit first, and a 1 is sent as `kd_n` low.
- R4: Index 0 to 9 is a digit key whose value equals the index (column 0 rows 0-7, column 1 rows 0-1). It first sends 7'h41, or 7'h43 once the decimal point has been entered.
- R5: After a digit code, each clock on which `tf_n` is sampled low shifts out the next BCD bit, least significant first. All four bits go out on four consecutive clocks.
- R6: While a digit waits for `tf_n`, `col_drive` holds still and no other key press produces any output on `kd_n`.
- R7: Index 10 is the decimal-point key. It sends its command code 7'h15 and sets a flag that selects 7'h43 for later digits. Both reset and clear drop this flag.
- R8: A clock with `clr_n` low aborts any transmission or wait. On the next clock `kd_n` is high and `col_drive` is 4'b0001. A later `tf_n` pulse sends nothing.
- R9: While `busy` is high, the scan index holds and no new report starts. The held key is reported once `busy` falls.
- R10: After a report, the block sends nothing more until the key has been released. A new press of the same key is then reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous active-low clear: abort, restart scan, drop decimal flag |
| busy | input | 1 | High while downstream logic is executing; blocks new reports |
| tf_n | input | 1 | Active-low figure strobe, four clocks wide, requests the BCD digit |
| row_in | input | 8 | Row sense lines, high where a pressed key meets the driven column |
| col_drive | output | 4 | One-hot column drive |
| kd_n | output | 1 | Active-low serial key data, LSB first |

## Verification
A wrong scan index shows up right away on `col_drive`, within eight clocks of reset, or as a code whose row and column fields do not match the key that was pressed. A decimal flag stuck high or low changes the very next digit code from 7'h41 to 7'h43 or the other way round. A state machine that leaves the figure wait too early shows up as traffic on `kd_n` while a second key is held or while `busy` is high. One that never leaves the wait shows up as a missing BCD digit in the four clocks of the strobe.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  typedef enum logic [1:0] {
    ST_SCAN     = 2'd0,
    ST_SEND     = 2'd1,
    ST_WAIT_FIG = 2'd2,
    ST_HOLD     = 2'd3
  } scan_st_e;

  localparam int CODE_W = 7;
  localparam int BCD_W  = 4;
  localparam logic [CODE_W-1:0] DIGIT_CODE_PLAIN = 7'h41;
  localparam logic [CODE_W-1:0] DIGIT_CODE_DP    = 7'h43;
endpackage

// File: rtl/kbd_scan_ctr.sv
module kbd_scan_ctr #(
  parameter int COLS = 4,
  parameter int ROWS = 8,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int IW = CW + RW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            advance,
  input  logic [ROWS-1:0] row_in,
  output logic [IW-1:0]   idx,
  output logic [COLS-1:0] col_drive,
  output logic            row_hit
);
  always_ff @(posedge clk) begin
    if (rst || restart) idx <= '0;
    else if (advance)   idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < COLS; g++) begin : g_col
    assign col_drive[g] = (idx[IW-1:RW] == CW'(g));
  end

  assign row_hit = row_in[idx[RW-1:0]];
endmodule

// File: rtl/kbd_key_encoder.sv
module kbd_key_encoder
  import kbd_scan_pkg::*;
#(
  parameter int IW     = 5,
  parameter int DIGITS = 10,
  parameter int DP_IDX = 10
) (
  input  logic [IW-1:0]     idx,
  input  logic              dp_seen,
  output logic [CODE_W-1:0] code,
  output logic [BCD_W-1:0]  bcd,
  output logic              is_digit,
  output logic              is_dp
);
  always_comb begin
    is_digit = (int'(idx) < DIGITS);
    is_dp    = (idx == IW'(DP_IDX));
    bcd      = BCD_W'(idx);
    if (is_digit) code = dp_seen ? DIGIT_CODE_DP : DIGIT_CODE_PLAIN;
    else          code = CODE_W'({idx, 1'b1});
  end
endmodule

// File: rtl/kbd_serializer.sv
module kbd_serializer #(
  parameter int W = 7,
  localparam int LW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic [LW-1:0] len,
  output logic         kd_n,
  output logic         active
);
  logic [W-1:0]  sr;
  logic [LW-1:0] rem;

  always_ff @(posedge clk) begin
    if (flush) begin
      kd_n <= 1'b1;
      sr   <= '0;
      rem  <= '0;
    end else if (load) begin
      kd_n <= ~data[0];
      sr   <= data >> 1;
      rem  <= len - 1'b1;
    end else if (rem != '0) begin
      kd_n <= ~sr[0];
      sr   <= sr >> 1;
      rem  <= rem - 1'b1;
    end else begin
      kd_n <= 1'b1;
    end
  end

  assign active = (rem != '0);
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_scan_pkg::*;
#(
  parameter int COLS   = 4,
  parameter int ROWS   = 8,
  parameter int DIGITS = 10,
  parameter int DP_IDX = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_n,
  input  logic            busy,
  input  logic            tf_n,
  input  logic [ROWS-1:0] row_in,
  output logic [COLS-1:0] col_drive,
  output logic            kd_n
);
  localparam int IW = $clog2(COLS) + $clog2(ROWS);
  localparam int LW = $clog2(CODE_W + 1);

  scan_st_e          st, after_st;
  logic              dp_seen;
  logic [IW-1:0]     idx;
  logic              row_hit, advance, flush, load, active;
  logic              is_digit, is_dp;
  logic [CODE_W-1:0] key_code, load_data;
  logic [BCD_W-1:0]  bcd;
  logic [LW-1:0]     load_len;
  logic              take_key, take_fig;

  assign flush    = rst || !clr_n;
  assign take_key = (st == ST_SCAN) && !busy && row_hit;
  assign take_fig = (st == ST_WAIT_FIG) && !tf_n;
  assign advance  = (st == ST_SCAN) && !busy && !row_hit;
  assign load     = take_key || take_fig;

  always_comb begin
    if (take_fig) begin
      load_data = CODE_W'(bcd);
      load_len  = LW'(BCD_W);
    end else begin
      load_data = key_code;
      load_len  = LW'(CODE_W);
    end
  end

  kbd_scan_ctr #(.COLS(COLS), .ROWS(ROWS)) u_ctr (
    .clk(clk), .rst(rst), .restart(!clr_n), .advance(advance),
    .row_in(row_in), .idx(idx), .col_drive(col_drive), .row_hit(row_hit)
  );

  kbd_key_encoder #(.IW(IW), .DIGITS(DIGITS), .DP_IDX(DP_IDX)) u_enc (
    .idx(idx), .dp_seen(dp_seen), .code(key_code), .bcd(bcd),
    .is_digit(is_digit), .is_dp(is_dp)
  );

  kbd_serializer #(.W(CODE_W)) u_ser (
    .clk(clk), .flush(flush), .load(load), .data(load_data),
    .len(load_len), .kd_n(kd_n), .active(active)
  );

  always_ff @(posedge clk) begin
    if (flush) begin
      st       <= ST_SCAN;
      after_st <= ST_HOLD;
      dp_seen  <= 1'b0;
    end else begin
      case (st)
        ST_SCAN: if (take_key) begin
          st       <= ST_SEND;
          after_st <= is_digit ? ST_WAIT_FIG : ST_HOLD;
          if (is_dp) dp_seen <= 1'b1;
        end
        ST_SEND: if (!active) st <= after_st;
        ST_WAIT_FIG: if (take_fig) begin
          st       <= ST_SEND;
          after_st <= ST_HOLD;
        end
        default: if (!row_hit) st <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/kbd_matrix_scanner_chk.sv
module kbd_matrix_scanner_chk
  import kbd_scan_pkg::*;
#(
  parameter int COLS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            clr_n,
  input logic            busy,
  input logic            tf_n,
  input logic [COLS-1:0] col_drive,
  input logic            kd_n,
  input scan_st_e        st
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (kd_n && col_drive == COLS'(1)));

  // R2
  col_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(col_drive) == 1);

  // R6
  wait_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_FIG && tf_n && clr_n) |=> (kd_n && $stable(col_drive)));

  // R8
  clear_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (kd_n && col_drive == COLS'(1)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && clr_n && st == ST_SCAN) |=> (kd_n && $stable(col_drive)));

  // R10
  release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && clr_n) |=> kd_n);
endmodule

bind kbd_matrix_scanner kbd_matrix_scanner_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .busy(busy), .tf_n(tf_n),
  .col_drive(col_drive), .kd_n(kd_n), .st(st)
);

// File: tb/test_kbd_matrix_scanner.sv
`timescale 1ns/1ps
module test_kbd_matrix_scanner;
  logic clk = 1'b0;
  logic rst = 1'b1, clr_n = 1'b1, busy = 1'b0, tf_n = 1'b1;
  logic [7:0] row_in;
  logic [3:0] col_drive;
  logic kd_n;
  logic       k1_on = 1'b0, k2_on = 1'b0;
  logic [4:0] k1_idx = '0, k2_idx = '0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] sense(logic on, logic [4:0] k, logic [3:0] cols);
    return (on && cols[k[4:3]]) ? (8'b1 << k[2:0]) : 8'b0;
  endfunction
  assign row_in = sense(k1_on, k1_idx, col_drive) | sense(k2_on, k2_idx, col_drive);

  kbd_matrix_scanner i_kbd_matrix_scanner (
    .clk(clk), .rst(rst), .clr_n(clr_n), .busy(busy), .tf_n(tf_n),
    .row_in(row_in), .col_drive(col_drive), .kd_n(kd_n)
  );

  // {index, digit flag, expected code, expected bcd}
  localparam logic [16:0] VEC [8] = '{
    {5'd3,  1'b1, 7'h41, 4'd3},
    {5'd20, 1'b0, 7'h29, 4'd0},
    {5'd9,  1'b1, 7'h41, 4'd9},
    {5'd10, 1'b0, 7'h15, 4'd0},
    {5'd0,  1'b1, 7'h43, 4'd0},
    {5'd7,  1'b1, 7'h43, 4'd7},
    {5'd31, 1'b0, 7'h3F, 4'd0},
    {5'd8,  1'b1, 7'h43, 4'd8}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=50000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic get_code(output logic [6:0] c);
    bit seen = 0;
    c = '0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (!kd_n) begin seen = 1; break; end
    end
    if (seen) begin
      c[0] = 1'b1;
      for (int i = 1; i < 7; i++) begin
        @(negedge clk);
        c[i] = ~kd_n;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic get_bcd(output logic [3:0] b);
    tf_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      b[i] = ~kd_n;
    end
    tf_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_key();
    k1_on = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic press(input logic [4:0] k);
    k1_idx = k;
    k1_on  = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [6:0] code;
    logic [3:0] bcd;
    logic [3:0] snap;
    int lows;
    bit moved;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(kd_n == 1'b1 && col_drive == 4'b0001, "R1 reset", {col_drive, kd_n}, 5'b00011);
    rst = 1'b0;

    // R2 free-running scan, column = (k mod 32) / 8 after k clocks
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (k == 7 || k == 8 || k == 16 || k == 24 || k == 31 || k == 32)
        chk(col_drive == (4'b1 << ((k % 32) / 8)), "R2 column order",
            col_drive, 4'b1 << ((k % 32) / 8));
    end

    // table walk: R3 command codes, R4 digit codes, R5 bcd, R7 decimal key
    for (int v = 0; v < 8; v++) begin
      press(VEC[v][16:12]);
      get_code(code);
      chk(code == VEC[v][10:4],
          VEC[v][16:12] == 5'd10 ? "R7 decimal code" : (VEC[v][11] ? "R4 digit code" : "R3 command code"),
          code, VEC[v][10:4]);
      if (VEC[v][11]) begin
        get_bcd(bcd);
        chk(bcd == VEC[v][3:0], "R5 bcd value", bcd, VEC[v][3:0]);
      end
      release_key();
    end

    // R7 reset drops the decimal flag
    do_reset();
    press(5'd4);
    get_code(code);
    chk(code == 7'h41, "R7 flag cleared by reset", code, 7'h41);
    get_bcd(bcd);
    chk(bcd == 4'd4, "R5 bcd after reset", bcd, 4'd4);
    release_key();

    // R7 clear drops the decimal flag
    press(5'd10);
    get_code(code);
    release_key();
    clr_n = 1'b0; @(negedge clk); clr_n = 1'b1;
    press(5'd2);
    get_code(code);
    chk(code == 7'h41, "R7 flag cleared by clear", code, 7'h41);
    get_bcd(bcd);
    release_key();

    // R6 frozen while waiting for the figure strobe
    press(5'd5);
    get_code(code);
    chk(code == 7'h41, "R6 setup digit code", code, 7'h41);
    snap = col_drive; lows = 0; moved = 0;
    k2_idx = 5'd25; k2_on = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (!kd_n) lows++;
      if (col_drive != snap) moved = 1;
    end
    k2_on = 1'b0;
    chk(lows == 0 && !moved, "R6 quiet and frozen", {lows, moved}, 0);
    get_bcd(bcd);
    chk(bcd == 4'd5, "R6 bcd after wait", bcd, 4'd5);
    release_key();

    // R8 clear aborts the wait
    press(5'd6);
    get_code(code);
    clr_n = 1'b0; @(negedge clk); clr_n = 1'b1;
    chk(kd_n == 1'b1 && col_drive == 4'b0001, "R8 clear restarts", {col_drive, kd_n}, 5'b00011);
    k1_on = 1'b0;
    tf_n = 1'b0; lows = 0;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      if (!kd_n) lows++;
    end
    tf_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(lows == 0, "R8 strobe after clear sends nothing", lows, 0);

    // R10 no repeat until released
    press(5'd17);
    get_code(code);
    chk(code == 7'h23, "R10 first report", code, 7'h23);
    lows = 0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (!kd_n) lows++;
    end
    chk(lows == 0, "R10 held key silent", lows, 0);
    release_key();
    press(5'd17);
    get_code(code);
    chk(code == 7'h23, "R10 report after release", code, 7'h23);
    release_key();

    // R9 busy holds off reports
    busy = 1'b1;
    @(negedge clk);
    snap = col_drive; lows = 0; moved = 0;
    press(5'd17);
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (!kd_n) lows++;
      if (col_drive != snap) moved = 1;
    end
    chk(lows == 0 && !moved, "R9 busy blocks scan", {lows, moved}, 0);
    busy = 1'b0;
    get_code(code);
    chk(code == 7'h23, "R9 report after busy", code, 7'h23);
    release_key();

    summary();
  end
endmodule